// File: doc/BRIEF.md
# Stepped Digital Attenuator with Soft Mute

This block is a multi-channel volume stage for a 24-bit audio path. Each channel carries an 8-bit attenuation code and a mute bit. A shared phase-invert bit and a per-channel disable bit complete the controls. The block scales each incoming sample by the gain that the channel's current level selects. The level never jumps to a new value. Instead it walks one 0.5 dB step at a time toward the target, taking a fixed number of sample periods per step, so volume changes and muting are free of clicks.

A sample-rate strobe paces the block. On every strobe each channel registers one output sample and may advance its level. The applied gain is split into a coarse right shift of one bit per 12 steps and a fine fractional mantissa from a 12-entry table. Rounding and saturation bring the result back to 24 bits.

Top module: `atten_stepper`

## Requirements
- R1: After reset, every channel reports level 255 (0 dB) and drives output sample 0.
- R2: The target level is the channel's code when the code is 129 to 255. It is 128 (silence) when the code is 0 to 128. The reported level therefore never drops below 128.
- R3: The level changes only at a clock edge that has the strobe high, and only by +1 or −1. A step happens on the STEP_PERIODS-th strobe (default 8) counted from the last step, or from the last strobe at which level and target were equal.
- R4: While mute is set, the target is 128 and the level steps down. Once mute is cleared, the level ramps back up to the code's target.
- R5: At level 128 the output sample is exactly 0.
- R6: At a level L from 129 to 255, let n = 255 − L, s = n / 12 and k = n mod 12. The output is floor((x·M[k] + 2^(15+s)) / 2^(16+s)), saturated to 24 bits, where M[k] = round(65536·10^(−k/40)).
- R7: When a channel's disable bit is set, its output sample is 0.
- R8: When the invert bit is set, the output is the negated result of R6. Negating −8388608 gives +8388607.
- R9: Each channel has its own level, code, mute and disable. A change on one channel leaves the others unaffected.
- R10: The output sample changes only at an edge with the strobe high. It is computed from the sample input and the level held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe per sample period |
| smp_i | input | NCH*DW | Signed input samples, one field per channel |
| code_i | input | NCH*8 | Attenuation code per channel |
| mute_i | input | NCH | Soft mute request per channel |
| dis_i | input | NCH | Forces the channel output to 0 |
| inv_i | input | 1 | Negates all channel outputs |
| smp_o | output | NCH*DW | Attenuated signed output samples |
| level_o | output | NCH*8 | Current applied level per channel |

## Verification
A step counter that is wrongly loaded or cleared shows up on level_o as a first step arriving on the wrong strobe after a code change. The bench catches this within eight strobes. A wrong shift or mantissa selection changes smp_o on the very next strobe after the level settles, and the vector table sweeps levels across several shift boundaries and mantissa indices to expose it. A mute ramp that moves the wrong way, or a level that slips below 128, appears on level_o within one step period. A stalled level appears as a ramp that never reaches its target within the bench's bound.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned MANT_W    = 17;
  localparam int unsigned FRAC_W    = 16;
  localparam int unsigned STEPS_OCT = 12;
  localparam logic [7:0]  LVL_TOP   = 8'd255;
  localparam logic [7:0]  LVL_SIL   = 8'd128;

  // round(65536 * 10^(-k/40))
  function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] k);
    case (k)
      4'd0:    mant_lut = 17'd65536;
      4'd1:    mant_lut = 17'd61870;
      4'd2:    mant_lut = 17'd58409;
      4'd3:    mant_lut = 17'd55142;
      4'd4:    mant_lut = 17'd52057;
      4'd5:    mant_lut = 17'd49145;
      4'd6:    mant_lut = 17'd46396;
      4'd7:    mant_lut = 17'd43801;
      4'd8:    mant_lut = 17'd41350;
      4'd9:    mant_lut = 17'd39037;
      4'd10:   mant_lut = 17'd36854;
      4'd11:   mant_lut = 17'd34792;
      default: mant_lut = 17'd0;
    endcase
  endfunction

  function automatic logic [7:0] tgt_of(input logic [7:0] code, input logic mute);
    if (mute || code <= LVL_SIL) tgt_of = LVL_SIL;
    else                         tgt_of = code;
  endfunction
endpackage

// File: rtl/atten_ramp.sv
module atten_ramp
  import atten_pkg::*;
#(
  parameter int unsigned STEP_PERIODS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic [7:0] code_i,
  input  logic       mute_i,
  output logic [7:0] lvl_o
);
  localparam int unsigned CW = (STEP_PERIODS > 1) ? $clog2(STEP_PERIODS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_PERIODS - 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    lvl_q;
  logic [7:0]    tgt;
  logic          at_tgt;
  logic          step_now;

  assign tgt      = tgt_of(code_i, mute_i);
  assign at_tgt   = (lvl_q == tgt);
  assign step_now = stb_i && !at_tgt && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= LVL_TOP;
    end else if (stb_i) begin
      if (at_tgt || step_now) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
      if (step_now) lvl_q <= (lvl_q < tgt) ? lvl_q + 8'd1 : lvl_q - 8'd1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/atten_gain.sv
module atten_gain
  import atten_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic signed [DW-1:0] x_i,
  input  logic        [7:0]    lvl_i,
  input  logic                 inv_i,
  input  logic                 dis_i,
  output logic signed [DW-1:0] y_o
);
  localparam int unsigned PW = DW + MANT_W + 1;
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] PMAX = PW'(YMAX);
  localparam logic signed [PW-1:0] PMIN = PW'(YMIN);

  logic        [7:0]    n;
  logic        [3:0]    sh;
  logic        [3:0]    k;
  logic        [5:0]    sa;
  logic signed [PW-1:0] prod, half, scaled;
  logic signed [DW-1:0] sat, neg;
  logic                 silent;

  always_comb begin
    silent = (lvl_i <= LVL_SIL);
    n      = LVL_TOP - lvl_i;
    sh     = 4'(n / 8'(STEPS_OCT));
    k      = 4'(n % 8'(STEPS_OCT));
    sa     = 6'(FRAC_W) + {2'b00, sh};
    prod   = PW'(x_i) * $signed({1'b0, mant_lut(k)});
    half   = $signed({{(PW-1){1'b0}}, 1'b1} << (sa - 6'd1));
    scaled = (prod + half) >>> sa;
    if (scaled > PMAX)      sat = YMAX;
    else if (scaled < PMIN) sat = YMIN;
    else                    sat = scaled[DW-1:0];
    neg = (sat == YMIN) ? YMAX : -sat;
    if (silent || dis_i) y_o = '0;
    else if (inv_i)      y_o = neg;
    else                 y_o = sat;
  end
endmodule

// File: rtl/atten_chan.sv
module atten_chan #(
  parameter int unsigned DW           = 24,
  parameter int unsigned STEP_PERIODS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  input  logic signed [DW-1:0] x_i,
  input  logic        [7:0]    code_i,
  input  logic                 mute_i,
  input  logic                 dis_i,
  input  logic                 inv_i,
  output logic signed [DW-1:0] y_o,
  output logic        [7:0]    lvl_o
);
  logic        [7:0]    lvl;
  logic signed [DW-1:0] y_d, y_q;

  atten_ramp #(.STEP_PERIODS(STEP_PERIODS)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (stb_i),
    .code_i(code_i),
    .mute_i(mute_i),
    .lvl_o (lvl)
  );

  atten_gain #(.DW(DW)) u_gain (
    .x_i  (x_i),
    .lvl_i(lvl),
    .inv_i(inv_i),
    .dis_i(dis_i),
    .y_o  (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    y_q <= '0;
    else if (stb_i) y_q <= y_d;
  end

  assign y_o   = y_q;
  assign lvl_o = lvl;
endmodule

// File: rtl/atten_stepper.sv
module atten_stepper #(
  parameter int unsigned NCH          = 2,
  parameter int unsigned DW           = 24,
  parameter int unsigned STEP_PERIODS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_stb_i,
  input  logic [NCH-1:0][DW-1:0]   smp_i,
  input  logic [NCH-1:0][7:0]      code_i,
  input  logic [NCH-1:0]           mute_i,
  input  logic [NCH-1:0]           dis_i,
  input  logic                     inv_i,
  output logic [NCH-1:0][DW-1:0]   smp_o,
  output logic [NCH-1:0][7:0]      level_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] y;
    atten_chan #(.DW(DW), .STEP_PERIODS(STEP_PERIODS)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stb_i (smp_stb_i),
      .x_i   ($signed(smp_i[c])),
      .code_i(code_i[c]),
      .mute_i(mute_i[c]),
      .dis_i (dis_i[c]),
      .inv_i (inv_i),
      .y_o   (y),
      .lvl_o (level_o[c])
    );
    assign smp_o[c] = y;
  end
endmodule

// File: rtl/atten_stepper_chk.sv
module atten_stepper_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   smp_stb_i,
  input logic [NCH-1:0][7:0]    code_i,
  input logic [NCH-1:0]         mute_i,
  input logic [NCH-1:0]         dis_i,
  input logic [NCH-1:0][DW-1:0] smp_o,
  input logic [NCH-1:0][7:0]    level_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_LEVEL_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_o[c] >= 8'd128); // R2
    AST_STEP_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o[c] != $past(level_o[c])) |->
        ((level_o[c] == $past(level_o[c]) + 8'd1) || (level_o[c] == $past(level_o[c]) - 8'd1))); // R3
    AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_stb_i |=> $stable(level_o[c])); // R3
    AST_MUTE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_stb_i && mute_i[c]) |=> (level_o[c] <= $past(level_o[c]))); // R4
    AST_SILENT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_stb_i && level_o[c] == 8'd128) |=> (smp_o[c] == '0)); // R5
    AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_stb_i && dis_i[c]) |=> (smp_o[c] == '0)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_stb_i |=> $stable(smp_o[c])); // R10
  end
endmodule

bind atten_stepper atten_stepper_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_stb_i(smp_stb_i),
  .code_i   (code_i),
  .mute_i   (mute_i),
  .dis_i    (dis_i),
  .smp_o    (smp_o),
  .level_o  (level_o)
);

// File: tb/tb_atten_stepper.sv
module tb_atten_stepper;
  localparam int NCH = 2;
  localparam int DW  = 24;
  localparam int NV  = 8;

  localparam int          V_CODE [NV] = '{255, 254, 243, 242, 231, 200, 130, 255};
  localparam int          V_X0   [NV] = '{1000000, -1000000, 8388607, -8388608, 123457, -5, 4000000, -8388608};
  localparam int          V_X1   [NV] = '{-7, 2500000, -3000001, 8388607, 0, 77777, -8388608, 42};
  localparam bit          V_INV  [NV] = '{0, 1, 0, 0, 1, 0, 1, 1};

  logic clk = 0;
  logic rst_ni = 0;
  logic smp_stb_i = 0;
  logic [NCH-1:0][DW-1:0] smp_i = '0;
  logic [NCH-1:0][7:0]    code_i;
  logic [NCH-1:0]         mute_i = '0;
  logic [NCH-1:0]         dis_i = '0;
  logic                   inv_i = 0;
  logic [NCH-1:0][DW-1:0] smp_o;
  logic [NCH-1:0][7:0]    level_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  atten_stepper dut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_stb_i(smp_stb_i), .smp_i(smp_i),
    .code_i(code_i), .mute_i(mute_i), .dis_i(dis_i), .inv_i(inv_i),
    .smp_o(smp_o), .level_o(level_o)
  );

  function automatic longint expv(int code, int x, bit inv);
    longint p, r;
    int n, s, k, m;
    if (code <= 128) return 0;
    n = 255 - code; s = n / 12; k = n % 12;
    m = $rtoi(65536.0 * (10.0 ** (-k / 40.0)) + 0.5);
    p = longint'(x) * longint'(m);
    r = (p + (longint'(1) <<< (15 + s))) >>> (16 + s);
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    if (inv) r = (r == -8388608) ? 8388607 : -r;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk); smp_stb_i = 1;
    @(negedge clk); smp_stb_i = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic ramp_to(int ch, int tgt, string req);
    for (int i = 0; i < 2000 && int'(level_o[ch]) != tgt; i++) pulse();
    chk(int'(level_o[ch]) == tgt, req, level_o[ch], tgt);
  endtask

  function automatic longint so(int ch);
    return longint'($signed(smp_o[ch]));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    code_i = {8'd255, 8'd255};
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      chk(level_o[c] == 8'd255, "R1 level", level_o[c], 255);
      chk(smp_o[c] == '0, "R1 sample", so(c), 0);
    end

    // R6 R8 R9 table: ch0 follows code, ch1 stays at 0 dB
    for (int v = 0; v < NV; v++) begin
      code_i[0] = 8'(V_CODE[v]);
      ramp_to(0, V_CODE[v], "R3 ramp");
      inv_i = V_INV[v];
      smp_i[0] = DW'(V_X0[v]);
      smp_i[1] = DW'(V_X1[v]);
      pulse();
      chk(so(0) == expv(V_CODE[v], V_X0[v], V_INV[v]), "R6 ch0 gain", so(0), expv(V_CODE[v], V_X0[v], V_INV[v]));
      chk(so(1) == expv(255, V_X1[v], V_INV[v]), "R9 ch1 gain", so(1), expv(255, V_X1[v], V_INV[v]));
      chk(level_o[1] == 8'd255, "R9 ch1 level", level_o[1], 255);
    end
    inv_i = 0;

    // R3 step timing
    code_i[0] = 8'd250;
    pulses(7);
    chk(level_o[0] == 8'd255, "R3 before 8th strobe", level_o[0], 255);
    pulse();
    chk(level_o[0] == 8'd254, "R3 on 8th strobe", level_o[0], 254);
    repeat (5) @(negedge clk);
    chk(level_o[0] == 8'd254, "R3 no strobe hold", level_o[0], 254);
    pulses(7);
    chk(level_o[0] == 8'd254, "R3 second step early", level_o[0], 254);
    pulse();
    chk(level_o[0] == 8'd253, "R3 second step", level_o[0], 253);
    ramp_to(0, 250, "R3 settle");

    // R4 R5 mute ramp
    mute_i[0] = 1;
    pulses(7);
    chk(level_o[0] == 8'd250, "R4 mute first step early", level_o[0], 250);
    pulse();
    chk(level_o[0] == 8'd249, "R4 mute steps down", level_o[0], 249);
    chk(level_o[1] == 8'd255, "R9 other channel unmuted", level_o[1], 255);
    ramp_to(0, 128, "R4 mute reaches silence");
    pulses(20);
    chk(level_o[0] == 8'd128, "R4 stays silent", level_o[0], 128);
    smp_i[0] = DW'(1000000);
    pulse();
    chk(smp_o[0] == '0, "R5 silent output", so(0), 0);
    mute_i[0] = 0;
    pulses(8);
    chk(level_o[0] == 8'd129, "R4 unmute steps up", level_o[0], 129);
    ramp_to(0, 250, "R4 unmute returns to code");

    // R2 low codes map to silence
    code_i[0] = 8'd100;
    ramp_to(0, 128, "R2 code 100 target");
    pulses(16);
    chk(level_o[0] == 8'd128, "R2 no step below 128", level_o[0], 128);
    smp_i[0] = DW'(-2000000);
    pulse();
    chk(smp_o[0] == '0, "R5 code 100 output", so(0), 0);
    code_i[0] = 8'd129;
    ramp_to(0, 129, "R2 code 129 target");
    smp_i[0] = DW'(8388607);
    pulse();
    chk(so(0) == expv(129, 8388607, 0), "R6 deepest level", so(0), expv(129, 8388607, 0));

    // R7 disable
    code_i[0] = 8'd255;
    ramp_to(0, 255, "R7 setup");
    dis_i[0] = 1;
    smp_i[0] = DW'(5000000);
    smp_i[1] = DW'(5000000);
    pulse();
    chk(smp_o[0] == '0, "R7 disabled output", so(0), 0);
    chk(so(1) == 5000000, "R9 enabled channel", so(1), 5000000);
    dis_i[0] = 0;

    // R10 output only on strobe
    smp_i[0] = DW'(300000);
    pulse();
    chk(so(0) == 300000, "R10 strobed sample", so(0), 300000);
    smp_i[0] = DW'(-123);
    repeat (4) @(negedge clk);
    chk(so(0) == 300000, "R10 hold without strobe", so(0), 300000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule